// File: doc/BRIEF.md
# TCP Receive Notification Client

This block sits on the application side of a hardware TCP engine and turns its data-available notices into read transactions. Each notice carries a session ID, a byte count and a closed flag. A notice that reports a closed session, or a zero byte count, produces no read. It raises a one-cycle session-closed pulse that carries the session ID instead. Any other notice starts a read request for that session and byte count.

After the request is accepted, the block takes one session-ID metadata word and then passes the byte-keyed response beats through to a local sink. Each beat is tagged with the session ID. Only one read is outstanding at a time. The notice channel stays stalled until the last response beat has been handed to the sink.

Two integrity checks run on every read. The sum of keep bits across the response must equal the requested byte count, and the metadata session ID must equal the requested one. A failure of either check sets a sticky error flag.

The controller has four states:
- `ST_IDLE` accepts notices. A data notice moves to `ST_REQ`. A closed or empty notice stays in `ST_IDLE`.
- `ST_REQ` presents the request and moves to `ST_META` when the request handshake completes.
- `ST_META` takes the metadata word and moves to `ST_DATA`.
- `ST_DATA` forwards beats and returns to `ST_IDLE` when the beat flagged last is accepted.

The notice's address and port fields are not used by this block and have no ports.

Top module: `tcp_rx_notify_client`

## Requirements
- R1: After reset the block is in `ST_IDLE`. `notif_ready` is 1, and `req_valid`, `meta_ready`, `rd_ready`, `snk_valid`, `closed_pulse` and `err_flag` are all 0.
- R2: A notice accepted with `notif_closed`=0 and `notif_length`≠0 is followed in the next cycle by `req_valid`=1, with `req_session` and `req_length` equal to the notice fields. These values hold steady until `req_ready` is seen.
- R3: A notice accepted with `notif_closed`=1 or `notif_length`=0 produces no request. In the cycle after acceptance, `closed_pulse` is 1 for exactly one cycle and `closed_session` holds the notice's session ID.
- R4: From the acceptance of a data notice until the cycle after the last response beat is accepted, `notif_ready` is 0. `notif_ready` returns to 1 in that following cycle.
- R5: `meta_ready` is raised only after the request handshake, and exactly one metadata word is taken. `rd_ready` stays 0 until that word has been accepted.
- R6: In `ST_DATA`, each beat reaches the sink with its data, keep and last unchanged, and `snk_session` equals the requested session. `snk_valid` follows `rd_valid` and `rd_ready` follows `snk_ready`, so no beat is lost under backpressure.
- R7: `err_flag` is set if the number of set keep bits summed over all beats up to and including the last beat differs from the requested length.
- R8: `err_flag` is set if the accepted metadata session ID differs from the requested session ID.
- R9: Once set, `err_flag` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| notif_valid | input | 1 | Notice valid |
| notif_ready | output | 1 | Notice ready |
| notif_session | input | SID_W | Notice session ID |
| notif_length | input | LEN_W | Notice byte count |
| notif_closed | input | 1 | Notice reports a closed session |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request ready |
| req_session | output | SID_W | Requested session ID |
| req_length | output | LEN_W | Requested byte count |
| meta_valid | input | 1 | Response metadata valid |
| meta_ready | output | 1 | Response metadata ready |
| meta_session | input | SID_W | Response session ID |
| rd_valid | input | 1 | Response beat valid |
| rd_ready | output | 1 | Response beat ready |
| rd_data | input | DATA_W | Response beat data |
| rd_keep | input | DATA_W/8 | Response byte keep mask |
| rd_last | input | 1 | Response last beat |
| snk_valid | output | 1 | Sink beat valid |
| snk_ready | input | 1 | Sink ready |
| snk_data | output | DATA_W | Sink beat data |
| snk_keep | output | DATA_W/8 | Sink byte keep mask |
| snk_last | output | 1 | Sink last beat |
| snk_session | output | SID_W | Session tag for the sink beat |
| closed_pulse | output | 1 | One-cycle session-closed indication |
| closed_session | output | SID_W | Session ID of the closed indication |
| err_flag | output | 1 | Sticky integrity error |

## Verification
The assertions check properties on every cycle:
- request fields stay stable while `req_ready` is low;
- a closed pulse occurs only after a closed or empty notice, and no request follows such a notice;
- the channels are mutually exclusive, so only one read is outstanding;
- backpressure passes straight through between the sink and the response channel;
- the error flag is sticky.

Only the bench scenarios can show the following:
- the exact request contents;
- the cycle in which the notice channel reopens;
- that every beat reaches the sink unchanged and tagged with the right session;
- that a keep-count or session mismatch raises the error flag while a matching response leaves it clear.

// File: rtl/tcp_rxn_pkg.sv
package tcp_rxn_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_META = 2'd2,
        ST_DATA = 2'd3
    } rxn_state_e;

endpackage

// File: rtl/rxn_keep_count.sv
// Population count of a byte keep mask, built as a generated adder chain.
module rxn_keep_count #(
    parameter int KEEP_W = 8,
    parameter int CNT_W  = $clog2(KEEP_W + 1)
) (
    input  logic [KEEP_W-1:0] keep,
    output logic [CNT_W-1:0]  count
);

    logic [CNT_W-1:0] partial [KEEP_W+1];

    assign partial[0] = '0;

    for (genvar i = 0; i < KEEP_W; i++) begin : g_sum
        assign partial[i+1] = partial[i] + CNT_W'(keep[i]);
    end

    assign count = partial[KEEP_W];

endmodule

// File: rtl/rxn_len_check.sv
// Accumulates delivered bytes and raises a sticky error on a length or session mismatch.
module rxn_len_check #(
    parameter int LEN_W = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_fire,
    input  logic             beat_last,
    input  logic [CNT_W-1:0] beat_bytes,
    input  logic [LEN_W-1:0] want_len,
    input  logic             meta_fire,
    input  logic             meta_bad,
    output logic             err_flag
);

    localparam int ACC_W = LEN_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_next;
    logic             len_bad;

    assign acc_next = acc_q + ACC_W'(beat_bytes);
    assign len_bad  = beat_fire && beat_last && (acc_next != ACC_W'(want_len));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (beat_fire) begin
            acc_q <= beat_last ? '0 : acc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (len_bad || (meta_fire && meta_bad)) begin
            err_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/tcp_rx_notify_client.sv
module tcp_rx_notify_client
    import tcp_rxn_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SID_W  = 16,
    parameter int LEN_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                notif_valid,
    output logic                notif_ready,
    input  logic [SID_W-1:0]    notif_session,
    input  logic [LEN_W-1:0]    notif_length,
    input  logic                notif_closed,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [SID_W-1:0]    req_session,
    output logic [LEN_W-1:0]    req_length,
    input  logic                meta_valid,
    output logic                meta_ready,
    input  logic [SID_W-1:0]    meta_session,
    input  logic                rd_valid,
    output logic                rd_ready,
    input  logic [DATA_W-1:0]   rd_data,
    input  logic [DATA_W/8-1:0] rd_keep,
    input  logic                rd_last,
    output logic                snk_valid,
    input  logic                snk_ready,
    output logic [DATA_W-1:0]   snk_data,
    output logic [DATA_W/8-1:0] snk_keep,
    output logic                snk_last,
    output logic [SID_W-1:0]    snk_session,
    output logic                closed_pulse,
    output logic [SID_W-1:0]    closed_session,
    output logic                err_flag
);

    localparam int KEEP_W = DATA_W / 8;
    localparam int CNT_W  = $clog2(KEEP_W + 1);

    rxn_state_e       state_q, state_d;
    logic [SID_W-1:0] sid_q;
    logic [LEN_W-1:0] len_q;
    logic             notif_fire, notif_is_data;
    logic             meta_fire, beat_fire;
    logic [CNT_W-1:0] beat_bytes;

    assign notif_fire    = notif_valid && notif_ready;
    assign notif_is_data = !notif_closed && (notif_length != '0);
    assign meta_fire     = meta_valid && meta_ready;
    assign beat_fire     = rd_valid && rd_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (notif_fire && notif_is_data)   state_d = ST_REQ;
            ST_REQ:  if (req_ready)                     state_d = ST_META;
            ST_META: if (meta_valid)                    state_d = ST_DATA;
            ST_DATA: if (beat_fire && rd_last)          state_d = ST_IDLE;
            default:                                    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        notif_ready = 1'b0;
        req_valid   = 1'b0;
        meta_ready  = 1'b0;
        rd_ready    = 1'b0;
        snk_valid   = 1'b0;
        unique case (state_q)
            ST_IDLE: notif_ready = 1'b1;
            ST_REQ:  req_valid   = 1'b1;
            ST_META: meta_ready  = 1'b1;
            ST_DATA: begin
                rd_ready  = snk_ready;
                snk_valid = rd_valid;
            end
            default: ;
        endcase
    end

    assign req_session = sid_q;
    assign req_length  = len_q;
    assign snk_data    = rd_data;
    assign snk_keep    = rd_keep;
    assign snk_last    = rd_last;
    assign snk_session = sid_q;

    // Captured request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sid_q <= '0;
            len_q <= '0;
        end else if (notif_fire && notif_is_data) begin
            sid_q <= notif_session;
            len_q <= notif_length;
        end
    end

    // Session-closed indication
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            closed_pulse   <= 1'b0;
            closed_session <= '0;
        end else begin
            closed_pulse <= notif_fire && !notif_is_data;
            if (notif_fire && !notif_is_data) begin
                closed_session <= notif_session;
            end
        end
    end

    rxn_keep_count #(
        .KEEP_W (KEEP_W),
        .CNT_W  (CNT_W)
    ) u_keep_count (
        .keep  (rd_keep),
        .count (beat_bytes)
    );

    rxn_len_check #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_len_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_fire  (beat_fire),
        .beat_last  (rd_last),
        .beat_bytes (beat_bytes),
        .want_len   (len_q),
        .meta_fire  (meta_fire),
        .meta_bad   (meta_session != sid_q),
        .err_flag   (err_flag)
    );

endmodule

// File: rtl/tcp_rx_notify_client_chk.sv
module tcp_rx_notify_client_chk #(
    parameter int SID_W = 16,
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             notif_valid,
    input logic             notif_ready,
    input logic [SID_W-1:0] notif_session,
    input logic [LEN_W-1:0] notif_length,
    input logic             notif_closed,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SID_W-1:0] req_session,
    input logic [LEN_W-1:0] req_length,
    input logic             meta_ready,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic             snk_valid,
    input logic             snk_ready,
    input logic             closed_pulse,
    input logic [SID_W-1:0] closed_session,
    input logic             err_flag
);

    p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_session) && $stable(req_length));

    p_pulse_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        closed_pulse |-> $past(notif_valid && notif_ready && (notif_closed || notif_length == '0))
                         && closed_session == $past(notif_session));

    p_no_req_on_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        notif_valid && notif_ready && (notif_closed || notif_length == '0) |=> !req_valid);

    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid || meta_ready || rd_ready) |-> !notif_ready);

    p_meta_before_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        meta_ready |-> !rd_ready && !req_valid);

    p_backpressure_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready |-> snk_valid && snk_ready);

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

bind tcp_rx_notify_client tcp_rx_notify_client_chk #(
    .SID_W (SID_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .notif_valid    (notif_valid),
    .notif_ready    (notif_ready),
    .notif_session  (notif_session),
    .notif_length   (notif_length),
    .notif_closed   (notif_closed),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_session    (req_session),
    .req_length     (req_length),
    .meta_ready     (meta_ready),
    .rd_valid       (rd_valid),
    .rd_ready       (rd_ready),
    .snk_valid      (snk_valid),
    .snk_ready      (snk_ready),
    .closed_pulse   (closed_pulse),
    .closed_session (closed_session),
    .err_flag       (err_flag)
);

// File: tb/tcp_rx_notify_client_bench.sv
module tcp_rx_notify_client_bench;

    localparam int DATA_W = 64;
    localparam int SID_W  = 16;
    localparam int LEN_W  = 16;
    localparam int KEEP_W = DATA_W / 8;

    logic clk = 1'b0;
    logic rst_n;
    logic notif_valid, notif_ready, notif_closed;
    logic [SID_W-1:0] notif_session;
    logic [LEN_W-1:0] notif_length;
    logic req_valid, req_ready;
    logic [SID_W-1:0] req_session;
    logic [LEN_W-1:0] req_length;
    logic meta_valid, meta_ready;
    logic [SID_W-1:0] meta_session;
    logic rd_valid, rd_ready, rd_last;
    logic [DATA_W-1:0] rd_data;
    logic [KEEP_W-1:0] rd_keep;
    logic snk_valid, snk_ready, snk_last;
    logic [DATA_W-1:0] snk_data;
    logic [KEEP_W-1:0] snk_keep;
    logic [SID_W-1:0] snk_session;
    logic closed_pulse;
    logic [SID_W-1:0] closed_session;
    logic err_flag;

    int checks = 0;
    int failures = 0;
    bit err_exp = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tcp_rx_notify_client #(.DATA_W(DATA_W), .SID_W(SID_W), .LEN_W(LEN_W)) u_tcp_rx_notify_client (
        .clk(clk), .rst_n(rst_n),
        .notif_valid(notif_valid), .notif_ready(notif_ready), .notif_session(notif_session),
        .notif_length(notif_length), .notif_closed(notif_closed),
        .req_valid(req_valid), .req_ready(req_ready), .req_session(req_session), .req_length(req_length),
        .meta_valid(meta_valid), .meta_ready(meta_ready), .meta_session(meta_session),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_keep(rd_keep), .rd_last(rd_last),
        .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_data(snk_data), .snk_keep(snk_keep),
        .snk_last(snk_last), .snk_session(snk_session),
        .closed_pulse(closed_pulse), .closed_session(closed_session), .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [KEEP_W-1:0] keep_mask(input int n);
        return KEEP_W'((64'd1 << n) - 64'd1);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; notif_valid = 0; req_ready = 0; meta_valid = 0; rd_valid = 0;
        rd_last = 0; rd_keep = '0; rd_data = '0; snk_ready = 0; notif_closed = 0;
        notif_session = '0; notif_length = '0; meta_session = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        err_exp = 1'b0;
        @(negedge clk); #1;
    endtask

    task automatic give_notice(input logic [SID_W-1:0] sid, input logic [LEN_W-1:0] len, input bit closed);
        notif_session = sid; notif_length = len; notif_closed = closed; notif_valid = 1'b1;
        #0;
        while (!notif_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1 notif_valid = 1'b0;
    endtask

    // Closed or empty notice: R3
    task automatic closed_txn(input logic [SID_W-1:0] sid, input bit closed);
        give_notice(sid, closed ? LEN_W'($urandom_range(0, 50)) : '0, closed);
        @(negedge clk); #1;
        chk(closed_pulse == 1'b1, "R3 pulse", closed_pulse, 1);
        chk(closed_session == sid, "R3 session", closed_session, sid);
        chk(req_valid == 1'b0, "R3 no request", req_valid, 0);
        @(negedge clk); #1;
        chk(closed_pulse == 1'b0, "R3 single cycle", closed_pulse, 0);
        chk(req_valid == 1'b0 && notif_ready == 1'b1, "R3 stays idle", {req_valid, notif_ready}, 2'b01);
    endtask

    // Data notice with full read: R2 R4 R5 R6 R7 R8
    task automatic data_txn(input logic [SID_W-1:0] sid, input logic [LEN_W-1:0] len,
                            input bit bad_meta, input int len_delta);
        int remaining;
        give_notice(sid, len, 1'b0);
        @(negedge clk); #1;
        chk(req_valid && req_session == sid && req_length == len, "R2 request",
            {req_valid, req_session, req_length}, {1'b1, sid, len});
        chk(notif_ready == 1'b0, "R4 stalled", notif_ready, 0);
        for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
            @(negedge clk); #1;
            chk(req_valid && req_session == sid && req_length == len, "R2 hold",
                {req_valid, req_session, req_length}, {1'b1, sid, len});
        end
        req_ready = 1'b1;
        @(posedge clk); #1 req_ready = 1'b0;
        @(negedge clk); #1;
        chk(meta_ready == 1'b1 && rd_ready == 1'b0 && notif_ready == 1'b0, "R5 meta first",
            {meta_ready, rd_ready, notif_ready}, 3'b100);
        meta_valid = 1'b1;
        meta_session = bad_meta ? sid ^ SID_W'(1) : sid;
        @(posedge clk); #1 meta_valid = 1'b0;
        if (bad_meta) err_exp = 1'b1;
        if (len_delta != 0) err_exp = 1'b1;
        remaining = int'(len) + len_delta;
        while (remaining > 0) begin
            int n;
            n = $urandom_range(1, KEEP_W);
            if (n > remaining) n = remaining;
            remaining -= n;
            @(negedge clk);
            rd_valid = 1'b1; rd_keep = keep_mask(n); rd_last = (remaining == 0);
            rd_data = {$urandom, $urandom};
            forever begin
                snk_ready = ($urandom_range(0, 3) != 0);
                #1;
                chk(snk_valid == 1'b1 && rd_ready == snk_ready, "R6 handshake",
                    {snk_valid, rd_ready}, {1'b1, snk_ready});
                if (rd_ready) break;
                @(negedge clk);
            end
            chk(snk_data == rd_data && snk_keep == rd_keep && snk_last == rd_last && snk_session == sid,
                "R6 beat", snk_data, rd_data);
            @(posedge clk); #1 rd_valid = 1'b0; rd_last = 1'b0;
        end
        @(negedge clk); #1;
        chk(notif_ready == 1'b1, "R4 reopen", notif_ready, 1);
        chk(err_flag == err_exp, bad_meta ? "R8 error" : "R7 error", err_flag, err_exp);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin @(posedge clk); wd++; end
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=done", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        do_reset();
        chk(notif_ready && !req_valid && !meta_ready && !rd_ready && !snk_valid && !closed_pulse && !err_flag,
            "R1 reset", {notif_ready, req_valid, meta_ready, rd_ready, snk_valid, closed_pulse, err_flag}, 7'b1000000);
        closed_txn(16'h0A0A, 1'b1);
        closed_txn(16'h0B0B, 1'b0);
        data_txn(16'h0001, 16'd8, 1'b0, 0);
        data_txn(16'h0002, 16'd1, 1'b0, 0);
        data_txn(16'h0003, 16'd37, 1'b0, 0);
        for (int i = 0; i < 30; i++) begin
            logic [SID_W-1:0] s;
            s = SID_W'($urandom);
            if ($urandom_range(0, 3) == 0) closed_txn(s, $urandom_range(0, 1) == 1);
            else data_txn(s, LEN_W'($urandom_range(1, 60)), 1'b0, 0);
        end
        data_txn(16'h0044, 16'd20, 1'b1, 0);            // R8
        data_txn(16'h0045, 16'd12, 1'b0, 0);            // R9 stays set
        chk(err_flag == 1'b1, "R9 sticky", err_flag, 1);
        do_reset();
        chk(err_flag == 1'b0, "R1 error cleared", err_flag, 0);
        data_txn(16'h0050, 16'd17, 1'b0, 1);            // R7 too many bytes
        do_reset();
        data_txn(16'h0051, 16'd17, 1'b0, -1);           // R7 too few bytes
        closed_txn(16'h0052, 1'b1);
        chk(err_flag == 1'b1, "R9 sticky after close", err_flag, 1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule